// File: doc/BRIEF.md
# Keyed-access watchdog timer

This block is a watchdog timer on a single-cycle register bus with byte enables. Software keeps it alive by writing a fixed pair of 16-bit key words to the counter register. A second fixed pair opens a short configuration window. Only inside that window can the control byte fields, the timeout and the servicing window be changed. Once enabled, the counter advances on ticks from one of four sources: every bus cycle, or one of three external enable pulses. When the count reaches the timeout, the block raises a reset request. The request stays high until the block itself is reset.

Servicing can be restricted to late in the count. A nonzero window value rejects any refresh that arrives while the count is still below it, and sets a status flag. Software clears that flag by writing a one to it. A counter-register write that breaks the key protocol while the watchdog is enabled is treated as a runaway program and raises the reset request at once.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, reset_req is 0 and the registers read as follows. Word 0 (byte offset 0) reads 0x0000_0020: enable off, update-permit on, source 0, flag clear. The counter (offset 4) reads 0. The timeout (offset 8) reads TOUT_RESET. The window (offset 12) reads 0.
- R2: Writing 0xA602 and then 0xB480 to the counter register (word 1) on consecutive bus writes is a refresh. It sets the count to 0 at the clock edge that accepts the second word.
- R3: Writing 0xC520 and then 0xD928 to the counter register on consecutive bus writes is an unlock. Writes to word 0, word 2 (timeout) and word 3 (window) take effect only at the UNLOCK_CYCLES clock edges that follow the unlock. Later writes are ignored.
- R4: In word 0, bit 7 enables counting and bit 5 is update-permit. After bit 5 has been written as 0, every later configuration write is ignored, even after a new unlock. While bit 7 is 0 the count does not change, except that a refresh still clears it.
- R5: Word 0 bits 9:8 select the tick source. Value 0 counts every clock cycle. Values 1, 2 and 3 count the pulses on tick_in[0], tick_in[1] and tick_in[2]. The count rises by one per selected tick.
- R6: When the count of an enabled watchdog equals the timeout, reset_req goes high one clock later. The count then stops. reset_req stays high until rst.
- R7: With a nonzero window value, a refresh that arrives while the count is below the window is rejected: the count is kept and the flag (word 0 bit 14) is set. Writing a one to bit 14 with byte enable 1 set clears the flag, with or without an unlock.
- R8: While enabled, some counter writes raise reset_req at the clock edge that accepts them: a value that is not a first key word when no sequence is pending, and anything other than 0xB480 after 0xA602. Any write to another register after 0xA602 does the same. While disabled, such writes have no effect on reset_req.
- R9: If the second unlock word does not come on the very next bus write, the unlock is aborted. Later configuration writes are then ignored.
- R10: Reads are registered: bus_rdata shows the addressed word one cycle after bus_rd. The counter word returns the current count, and bits 31:16 of word 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Word index (byte offset divided by 4) |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_in | input | 3 | Tick pulses for sources 1 to 3 |
| reset_req | output | 1 | Sticky reset request |

## Verification
A corrupted key-sequence state shows up within one bus write: a refresh either fails to zero the count or falsely raises reset_req at the edge that accepts the second word. A wrong configuration-window count shows up as a timeout write that lands or is dropped at exactly the edge after the last open cycle. A faulty tick or expiry path shows up in the count read back after a known number of pulses, or in reset_req rising one cycle early or late. A broken sticky request drops reset_req in the cycles after expiry.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam logic [15:0] KEY_REF_A = 16'hA602;
  localparam logic [15:0] KEY_REF_B = 16'hB480;
  localparam logic [15:0] KEY_UNL_A = 16'hC520;
  localparam logic [15:0] KEY_UNL_B = 16'hD928;

  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_CNT  = 2'd1;
  localparam logic [1:0] W_TOUT = 2'd2;
  localparam logic [1:0] W_WIN  = 2'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REF  = 2'd1,
    SEQ_UNL  = 2'd2
  } seq_t;
endpackage

// File: rtl/keyed_wdt_keyseq.sv
module keyed_wdt_keyseq
  import keyed_wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic        to_cnt,
  input  logic [15:0] key,
  output logic        refresh_pls,
  output logic        unlock_pls,
  output logic        fault_pls
);
  seq_t st, st_nxt;

  always_comb begin
    st_nxt      = st;
    refresh_pls = 1'b0;
    unlock_pls  = 1'b0;
    fault_pls   = 1'b0;
    if (wr) begin
      case (st)
        SEQ_IDLE: begin
          if (to_cnt) begin
            if (key == KEY_REF_A)      st_nxt = SEQ_REF;
            else if (key == KEY_UNL_A) st_nxt = SEQ_UNL;
            else                       fault_pls = 1'b1;
          end
        end
        SEQ_REF: begin
          st_nxt = SEQ_IDLE;
          if (to_cnt && key == KEY_REF_B) refresh_pls = 1'b1;
          else                            fault_pls   = 1'b1;
        end
        SEQ_UNL: begin
          st_nxt = SEQ_IDLE;
          if (to_cnt && key == KEY_UNL_B)
            unlock_pls = 1'b1;
          else if (to_cnt && key != KEY_REF_A && key != KEY_UNL_A)
            fault_pls = 1'b1;
        end
        default: st_nxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SEQ_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/keyed_wdt_cfg.sv
module keyed_wdt_cfg
  import keyed_wdt_pkg::*;
#(
  parameter int BUS_W         = 32,
  parameter int SEL_W         = 2,
  parameter logic [BUS_W-1:0] TOUT_RESET = 32'h0000_1500,
  parameter int UNLOCK_CYCLES = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [1:0]         word,
  input  logic [BUS_W/8-1:0] be,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               unlock_pls,
  input  logic               flag_set,
  output logic               en,
  output logic               upd,
  output logic [SEL_W-1:0]   sel,
  output logic               flag,
  output logic [BUS_W-1:0]   tout,
  output logic [BUS_W-1:0]   win,
  output logic               open
);
  localparam int BYTES = BUS_W / 8;
  localparam int OW    = $clog2(UNLOCK_CYCLES + 1);

  logic [OW-1:0] open_cnt;
  logic          wr_ok;

  assign open  = (open_cnt != '0) && upd;
  assign wr_ok = wr && open;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_cnt <= '0;
      en       <= 1'b0;
      upd      <= 1'b1;
      sel      <= '0;
      flag     <= 1'b0;
      tout     <= TOUT_RESET;
      win      <= '0;
    end else begin
      if (unlock_pls)
        open_cnt <= OW'(UNLOCK_CYCLES);
      else if (open_cnt != '0)
        open_cnt <= open_cnt - 1'b1;

      if (flag_set)
        flag <= 1'b0 | 1'b1;
      else if (wr && word == W_CTRL && be[1] && wdata[14])
        flag <= 1'b0;

      if (wr_ok && word == W_CTRL) begin
        if (be[0]) begin
          en  <= wdata[7];
          upd <= wdata[5];
        end
        if (be[1]) sel <= wdata[8 +: SEL_W];
      end
      for (int b = 0; b < BYTES; b++) begin
        if (wr_ok && word == W_TOUT && be[b]) tout[b*8 +: 8] <= wdata[b*8 +: 8];
        if (wr_ok && word == W_WIN  && be[b]) win[b*8 +: 8]  <= wdata[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] tout,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  logic at_limit;

  assign at_limit = (cnt >= tout);
  assign expired  = en && at_limit;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (clear)                  cnt <= '0;
    else if (en && tick && !at_limit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int BUS_W         = 32,
  parameter int NUM_EXT       = 3,
  parameter logic [BUS_W-1:0] TOUT_RESET = 32'h0000_1500,
  parameter int UNLOCK_CYCLES = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [BUS_W/8-1:0] bus_be,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_EXT-1:0] tick_in,
  output logic               reset_req
);
  localparam int SEL_W = $clog2(NUM_EXT + 1);

  logic               refresh_pls, unlock_pls, fault_pls;
  logic               refresh_ok, refresh_rej;
  logic               cfg_en, cfg_upd, cfg_flag, cfg_open;
  logic [SEL_W-1:0]   cfg_sel;
  logic [BUS_W-1:0]   cfg_tout, cfg_win, cnt_val;
  logic               expired, tick_sel;
  logic [NUM_EXT:0]   src_vec;
  logic [7:0]         ctrl1_rd, ctrl2_rd;

  keyed_wdt_keyseq u_seq (
    .clk(clk), .rst(rst), .wr(bus_wr), .to_cnt(bus_addr == W_CNT),
    .key(bus_wdata[15:0]), .refresh_pls(refresh_pls),
    .unlock_pls(unlock_pls), .fault_pls(fault_pls)
  );

  assign refresh_ok  = refresh_pls && ((cfg_win == '0) || (cnt_val >= cfg_win));
  assign refresh_rej = refresh_pls && !refresh_ok;

  keyed_wdt_cfg #(
    .BUS_W(BUS_W), .SEL_W(SEL_W), .TOUT_RESET(TOUT_RESET),
    .UNLOCK_CYCLES(UNLOCK_CYCLES)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .word(bus_addr), .be(bus_be),
    .wdata(bus_wdata), .unlock_pls(unlock_pls), .flag_set(refresh_rej),
    .en(cfg_en), .upd(cfg_upd), .sel(cfg_sel), .flag(cfg_flag),
    .tout(cfg_tout), .win(cfg_win), .open(cfg_open)
  );

  assign src_vec[0] = 1'b1;
  generate
    for (genvar i = 0; i < NUM_EXT; i++) begin : g_src
      assign src_vec[i+1] = tick_in[i];
    end
  endgenerate
  assign tick_sel = src_vec[cfg_sel];

  keyed_wdt_counter #(.CNT_W(BUS_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cfg_en), .tick(tick_sel), .clear(refresh_ok),
    .tout(cfg_tout), .cnt(cnt_val), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  reset_req <= 1'b0;
    else if (expired || (cfg_en && fault_pls)) reset_req <= 1'b1;
  end

  assign ctrl1_rd = {cfg_en, 1'b0, cfg_upd, 5'b0};
  assign ctrl2_rd = {1'b0, cfg_flag, {(6-SEL_W){1'b0}}, cfg_sel};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        W_CTRL:  bus_rdata <= {{(BUS_W-16){1'b0}}, ctrl2_rd, ctrl1_rd};
        W_CNT:   bus_rdata <= cnt_val;
        W_TOUT:  bus_rdata <= cfg_tout;
        default: bus_rdata <= cfg_win;
      endcase
    end
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reset_req,
  input logic             cfg_en,
  input logic             cfg_open,
  input logic             refresh_ok,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cfg_tout,
  input logic [CNT_W-1:0] cfg_win
);
  assert_req_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);

  assert_refresh_clears_R2: assert property (@(posedge clk) disable iff (rst)
    refresh_ok |=> (cnt_val == '0));

  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !refresh_ok) |=> $stable(cnt_val));

  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> ($stable(cfg_tout) && $stable(cfg_win)));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !refresh_ok) |=>
      ((cnt_val == $past(cnt_val)) || (cnt_val == $past(cnt_val) + CNT_W'(1))));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .reset_req(reset_req), .cfg_en(cfg_en),
  .cfg_open(cfg_open), .refresh_ok(refresh_ok), .cnt_val(cnt_val),
  .cfg_tout(cfg_tout), .cfg_win(cfg_win)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;
  localparam logic [31:0] TOUT_RST = 32'h0000_1500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [2:0]  tick_in = 3'b000;
  logic        reset_req;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  keyed_wdt #(.TOUT_RESET(TOUT_RST)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(2'd1, 4'hF, 32'h0000_C520);
    wr(2'd1, 4'hF, 32'h0000_D928);
  endtask

  task automatic refresh();
    wr(2'd1, 4'hF, 32'h0000_A602);
    wr(2'd1, 4'hF, 32'h0000_B480);
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      tick_in[idx] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_in[idx] = 1'b0;
    end
  endtask

  task automatic configure(input logic [1:0] sel, input logic [31:0] tout,
                           input logic [31:0] win, input logic [7:0] c1);
    unlock();
    wr(2'd0, 4'h2, {22'd0, sel, 8'd0});
    wr(2'd2, 4'hF, tout);
    wr(2'd3, 4'hF, win);
    wr(2'd0, 4'h1, {24'd0, c1});
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    check("R1 reset_req", {31'd0, reset_req}, 32'd0);
    rd(2'd0, v); check("R1 word0 / R10 reserved bytes", v, 32'h0000_0020);
    rd(2'd1, v); check("R1 count", v, 32'd0);
    rd(2'd2, v); check("R1 timeout", v, TOUT_RST);
    rd(2'd3, v); check("R1 window", v, 32'd0);
  endtask

  task automatic t_sources();
    logic [31:0] v, v2;
    do_reset();
    configure(2'd1, 32'd1000, 32'd0, 8'hA0);
    pulse(0, 5);
    pulse(1, 3);
    rd(2'd1, v); check("R5 source 1 counts tick_in[0] only", v, 32'd5);
    unlock();
    wr(2'd0, 4'h2, 32'h0000_0200);
    pulse(1, 4);
    pulse(0, 2);
    rd(2'd1, v); check("R5 source 2 counts tick_in[1] only", v, 32'd9);
    unlock();
    wr(2'd0, 4'h2, 32'h0000_0000);
    rd(2'd1, v);
    rd(2'd1, v2);
    check("R5 source 0 counts every cycle", v2, v + 32'd1);
    check("R8 no fault from key writes", {31'd0, reset_req}, 32'd0);
  endtask

  task automatic t_refresh();
    logic [31:0] v;
    do_reset();
    configure(2'd1, 32'd1000, 32'd0, 8'hA0);
    pulse(0, 6);
    rd(2'd1, v); check("R10 count read", v, 32'd6);
    refresh();
    rd(2'd1, v); check("R2 refresh clears count", v, 32'd0);
    check("R2 refresh raises no request", {31'd0, reset_req}, 32'd0);
  endtask

  task automatic t_expiry();
    logic [31:0] v;
    do_reset();
    configure(2'd1, 32'd3, 32'd0, 8'hA0);
    pulse(0, 3);
    check("R6 not yet at count==timeout", {31'd0, reset_req}, 32'd0);
    @(negedge clk);
    check("R6 request one cycle after expiry", {31'd0, reset_req}, 32'd1);
    pulse(0, 2);
    rd(2'd1, v); check("R6 count stops at timeout", v, 32'd3);
    repeat (5) @(negedge clk);
    check("R6 request held", {31'd0, reset_req}, 32'd1);
  endtask

  task automatic t_bad_seq();
    do_reset();
    wr(2'd1, 4'hF, 32'h0000_1234);
    check("R8 junk while disabled ignored", {31'd0, reset_req}, 32'd0);
    configure(2'd1, 32'd1000, 32'd0, 8'hA0);
    wr(2'd1, 4'hF, 32'h0000_1234);
    check("R8 junk while enabled", {31'd0, reset_req}, 32'd1);
    do_reset();
    configure(2'd1, 32'd1000, 32'd0, 8'hA0);
    wr(2'd1, 4'hF, 32'h0000_A602);
    wr(2'd1, 4'hF, 32'h0000_0000);
    check("R8 broken refresh", {31'd0, reset_req}, 32'd1);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    do_reset();
    wr(2'd1, 4'hF, 32'h0000_C520);
    wr(2'd2, 4'hF, 32'h0000_0005);
    wr(2'd1, 4'hF, 32'h0000_D928);
    wr(2'd2, 4'hF, 32'h0000_0006);
    rd(2'd2, v); check("R9 aborted unlock leaves timeout", v, TOUT_RST);
  endtask

  task automatic t_window();
    logic [31:0] v;
    do_reset();
    configure(2'd1, 32'd100, 32'd4, 8'hA0);
    pulse(0, 2);
    refresh();
    rd(2'd1, v); check("R7 early refresh keeps count", v, 32'd2);
    rd(2'd0, v); check("R7 flag set", (v >> 14) & 32'd1, 32'd1);
    wr(2'd0, 4'h2, 32'h0000_4100);
    rd(2'd0, v); check("R7 flag cleared by one", (v >> 14) & 32'd1, 32'd0);
    pulse(0, 3);
    refresh();
    rd(2'd1, v); check("R7 late refresh accepted", v, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    unlock();
    repeat (127) @(negedge clk);
    wr(2'd2, 4'hF, 32'd1500);
    wr(2'd2, 4'hF, 32'd2200);
    rd(2'd2, v); check("R3 last open cycle accepted, next ignored", v, 32'd1500);
    wr(2'd3, 4'hF, 32'd9);
    rd(2'd3, v); check("R3 window write after close ignored", v, 32'd0);
    unlock();
    wr(2'd0, 4'h1, 32'h0000_0080);
    unlock();
    wr(2'd2, 4'hF, 32'd77);
    rd(2'd2, v); check("R4 update-permit cleared locks config", v, 32'd1500);
    rd(2'd1, v); check("R4 enable bit starts counting", {31'd0, (v != 0)}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_sources();
    t_refresh();
    t_expiry();
    t_bad_seq();
    t_abort();
    t_window();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule